// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital front of an analog-to-digital converter. It holds one 8-bit control and status register written and read by a CPU. It runs conversions over a start/done handshake with an external converter, and it keeps one result register per channel. It can run in two modes:

- **Single mode** converts one chosen channel once and then drops its start bit.
- **Scan mode** walks channels 0 up to the chosen index in order and repeats. It keeps going until software clears the start bit or standby is asserted.

A completion flag records finished work. It drives an interrupt request when enabled. Software clears it with a read-then-write-zero sequence, or a DMA read of a result clears it. A falling edge on an external trigger pin can also start conversion when enabled.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset every register field reads 0, `irq` is 0 and `conv_start` is 0. The register layout is: bit 7 done flag, bit 6 interrupt enable, bit 5 start, bit 4 scan (0 single, 1 scan), bit 3 trigger enable, bit 2 reads 0, bits 1:0 channel index.
- R2: In single mode, writing start=1 issues one conversion on the channel index. When `conv_done` arrives, `conv_data` is stored for that channel, the start bit returns to 0 and the done flag is set.
- R3: In scan mode, conversions are issued on channels 0,1,…,index and then repeat from 0. The done flag is set only when the conversion of the highest channel in the group completes, and the start bit stays 1.
- R4: A write with bit 7 = 0 clears the done flag only if the flag was read as 1 since the last write. Without that read, the flag stays set, and writing 1 to bit 7 never sets it.
- R5: A pulse on `dma_rd` clears the done flag.
- R6: `irq` is 1 exactly when both the done flag and the interrupt enable are 1.
- R7: The start bit reads 1 while a conversion is issued or in flight, and `conv_start` is a single-cycle pulse per conversion.
- R8: A write to the scan bit is ignored while the start bit is 1.
- R9: With trigger enable = 1 and start = 0, a falling edge on `trig_in` (seen through a two-stage synchronizer) sets the start bit and begins conversion. With trigger enable = 0, the pin has no effect.
- R10: Writing start = 0 or asserting `standby` during a conversion aborts it at once. No result is stored and the done flag is not set.
- R11: When a conversion completes in the same cycle as a flag clear (by write or by `dma_rd`), the done flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | CPU write strobe for the control register |
| reg_rd | input | 1 | CPU read strobe for the control register |
| wdata | input | 8 | CPU write data |
| csr_rdata | output | 8 | Control register contents |
| res_sel | input | 2 | Channel whose result is shown |
| res_data | output | 10 | Stored result of the selected channel |
| dma_rd | input | 1 | DMA read of a result, clears the done flag |
| trig_in | input | 1 | Asynchronous external start trigger |
| standby | input | 1 | Halts conversion and clears the start bit |
| conv_start | output | 1 | Start pulse to the converter |
| conv_ch | output | 2 | Channel for the conversion being started |
| conv_done | input | 1 | Converter completion pulse |
| conv_data | input | 10 | Converter result, valid with `conv_done` |
| irq | output | 1 | Interrupt request |

## Verification
The done flag can be set by a finishing conversion in the same cycle that it is cleared, either by an armed CPU write of zero or by a DMA read.

The bench provokes both collisions in scan mode with a group of one channel, so that every completion sets the flag. It first arms the clear with a read. It then watches its own converter model and drives the write or the `dma_rd` pulse in exactly the cycle the model raises `conv_done`. The flag must still read 1 afterwards. A clear issued away from any completion must then take effect.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int NCH = 4,
  parameter int DW  = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [7:0]             wdata,
  output logic [7:0]             csr_rdata,
  input  logic [$clog2(NCH)-1:0] res_sel,
  output logic [DW-1:0]          res_data,
  input  logic                   dma_rd,
  input  logic                   trig_in,
  input  logic                   standby,
  output logic                   conv_start,
  output logic [$clog2(NCH)-1:0] conv_ch,
  input  logic                   conv_done,
  input  logic [DW-1:0]          conv_data,
  output logic                   irq
);
  localparam int CW = $clog2(NCH);

  logic          flag, ie, go, scan, ten, busy, armed;
  logic [CW-1:0] chan, cur;
  logic          t1, t2, t3;
  logic [DW-1:0] res [NCH];

  logic          wr_go, wr_stop, trig_fall, start_now, abort, last;
  logic          done_ok, flag_set, flag_clr, new_scan;
  logic [CW-1:0] new_chan;

  assign wr_go     = reg_wr & wdata[5];
  assign wr_stop   = reg_wr & ~wdata[5];
  assign trig_fall = ten & t3 & ~t2;
  assign start_now = ~go & ~standby & (wr_go | (trig_fall & ~reg_wr));
  assign abort     = go & (standby | wr_stop);
  assign new_scan  = (reg_wr & ~go) ? wdata[4] : scan;
  assign new_chan  = reg_wr ? wdata[CW-1:0] : chan;
  assign last      = ~scan | (cur >= chan);
  assign done_ok   = busy & conv_done & ~abort;
  assign flag_set  = done_ok & last;
  assign flag_clr  = dma_rd | (reg_wr & ~wdata[7] & armed);

  assign conv_start = go & ~busy;
  assign conv_ch    = cur;
  assign irq        = flag & ie;
  assign res_data   = res[res_sel];

  always_comb begin
    csr_rdata         = '0;
    csr_rdata[7]      = flag;
    csr_rdata[6]      = ie;
    csr_rdata[5]      = go;
    csr_rdata[4]      = scan;
    csr_rdata[3]      = ten;
    csr_rdata[CW-1:0] = chan;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {flag, ie, go, scan, ten, busy, armed} <= '0;
      chan <= '0;
      cur  <= '0;
      {t1, t2, t3} <= '0;
      for (int i = 0; i < NCH; i++) res[i] <= '0;
    end else begin
      t1 <= trig_in;
      t2 <= t1;
      t3 <= t2;
      if (reg_wr) begin
        ie   <= wdata[6];
        ten  <= wdata[3];
        chan <= wdata[CW-1:0];
        if (!go) scan <= wdata[4];
      end
      flag <= flag_set | (flag & ~flag_clr);
      if (reg_wr || flag_clr) armed <= 1'b0;
      else if (reg_rd && flag) armed <= 1'b1;

      if (start_now) begin
        go  <= 1'b1;
        cur <= new_scan ? '0 : new_chan;
      end else if (abort) begin
        go   <= 1'b0;
        busy <= 1'b0;
      end else begin
        if (conv_start) busy <= 1'b1;
        if (done_ok) begin
          busy     <= 1'b0;
          res[cur] <= conv_data;
          if (!scan) go <= 1'b0;
          else       cur <= last ? '0 : cur + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [7:0] wdata,
  input logic       standby,
  input logic       dma_rd,
  input logic       conv_start,
  input logic       conv_done,
  input logic       busy,
  input logic [7:0] csr_rdata,
  input logic       irq
);
  assert_start_reads_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> csr_rdata[5]);
  assert_start_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  assert_scan_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && csr_rdata[5]) |=> csr_rdata[4] == $past(csr_rdata[4]));
  assert_flag_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csr_rdata[7]) |-> $past(busy && conv_done));
  assert_flag_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csr_rdata[7]) |-> $past(reg_wr || dma_rd));
  assert_single_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && conv_done && !csr_rdata[4] && !reg_wr && !standby) |=> !csr_rdata[5]);
  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && !wdata[5]) |=> !$rose(csr_rdata[7]) && !busy);
  assert_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (csr_rdata[7] && csr_rdata[6]));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .wdata(wdata), .standby(standby),
  .dma_rd(dma_rd), .conv_start(conv_start), .conv_done(conv_done), .busy(busy),
  .csr_rdata(csr_rdata), .irq(irq)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 4;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0, dma_rd = 0, trig_in = 0, standby = 0;
  logic [7:0] wdata = 0, csr_rdata;
  logic [1:0] res_sel = 0, conv_ch;
  logic [9:0] res_data, conv_data;
  logic conv_start, conv_done, irq;

  int total = 0, fails = 0, nstart = 0;
  logic [1:0] slog [256];
  logic [3:0] cnt;
  logic [1:0] mch;
  logic [7:0] seq;
  logic [9:0] last_data [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .wdata(wdata),
    .csr_rdata(csr_rdata), .res_sel(res_sel), .res_data(res_data), .dma_rd(dma_rd),
    .trig_in(trig_in), .standby(standby), .conv_start(conv_start), .conv_ch(conv_ch),
    .conv_done(conv_done), .conv_data(conv_data), .irq(irq)
  );

  assign conv_done = (cnt == 4'd1);
  assign conv_data = {mch, seq};

  always @(posedge clk) begin
    if (!rst_n) begin
      cnt <= 0; mch <= 0; seq <= 8'h11;
      for (int i = 0; i < 4; i++) last_data[i] <= '0;
    end else begin
      if (conv_start) begin
        cnt <= LAT[3:0]; mch <= conv_ch;
        if (nstart < 256) slog[nstart] <= conv_ch;
        nstart <= nstart + 1;
      end else if (cnt != 0) cnt <= cnt - 1'b1;
      if (cnt == 4'd1) begin
        seq <= seq + 1'b1;
        last_data[mch] <= {mch, seq};
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_wr = 1; wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk); reg_rd = 1; d = csr_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wait_flag(input string req);
    int n = 0;
    while (!csr_rdata[7] && n < 200) begin @(negedge clk); n++; end
    check(csr_rdata[7], req, csr_rdata[7], 1);
  endtask

  task automatic clr_flag(input logic [7:0] keep);
    logic [7:0] d;
    rd(d);
    wr(keep & 8'h7f);
  endtask

  function automatic logic [9:0] get_res(input logic [1:0] ch);
    return last_data[ch];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [9:0] saved;
    int s0, n;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(csr_rdata == 8'h00 && !irq && !conv_start, "R1 reset", csr_rdata, 0);

    // R2 single conversion on channel 2
    wr(8'h22);
    check(csr_rdata[5], "R7 start reads 1 during conversion", csr_rdata[5], 1);
    wait_flag("R2 flag after single");
    res_sel = 2'd2; #1;
    check(res_data == get_res(2'd2), "R2 result ch2", res_data, get_res(2'd2));
    check(!csr_rdata[5], "R2 start cleared", csr_rdata[5], 0);

    // R4 write 0 without read keeps flag
    wr(8'h02);
    check(csr_rdata[7], "R4 unarmed write", csr_rdata[7], 1);
    // R6 irq with enable
    wr(8'h42);
    check(irq, "R6 irq enabled", irq, 1);
    wr(8'h02);
    check(!irq && csr_rdata[7], "R6 irq disabled", irq, 0);
    // R4 read then write 0 clears
    clr_flag(8'h42);
    check(!csr_rdata[7] && !irq, "R4 armed clear", csr_rdata[7], 0);

    // R5 DMA clear
    wr(8'h21);
    wait_flag("R2 flag ch1");
    @(negedge clk); dma_rd = 1; @(negedge clk); dma_rd = 0;
    check(!csr_rdata[7], "R5 dma clear", csr_rdata[7], 0);

    // R3 scan of channels 0..2
    s0 = nstart;
    wr(8'h32);
    n = 0;
    while (nstart < s0 + 3 && n < 200) begin @(negedge clk); n++; end
    check(!csr_rdata[7], "R3 flag not set before group end", csr_rdata[7], 0);
    n = 0;
    while (nstart < s0 + 7 && n < 200) begin @(negedge clk); n++; end
    for (int k = 0; k < 7; k++)
      check(slog[s0 + k] == 2'(k % 3), "R3 scan order", slog[s0 + k], k % 3);
    check(csr_rdata[7] && csr_rdata[5], "R3 flag set, start held", csr_rdata, 8'hb2);
    // R8 scan bit write ignored while running
    wr(8'h22);
    check(csr_rdata[4], "R8 scan locked", csr_rdata[4], 1);
    // R10 stop aborts
    wr(8'h02);
    s0 = nstart;
    repeat (LAT + 4) @(negedge clk);
    check(!csr_rdata[5] && nstart == s0, "R10 scan stopped", nstart - s0, 0);
    clr_flag(8'h00);
    check(!csr_rdata[7] && !csr_rdata[4], "R8 scan writable when idle", csr_rdata, 0);

    // R11 collisions in scan with a group of one channel
    wr(8'h30);
    wait_flag("R3 flag group of one");
    rd(d);
    while (!conv_done) @(negedge clk);
    reg_wr = 1; wdata = 8'h30; @(negedge clk); reg_wr = 0;
    check(csr_rdata[7], "R11 set wins over write clear", csr_rdata[7], 1);
    while (!conv_done) @(negedge clk);
    dma_rd = 1; @(negedge clk); dma_rd = 0;
    check(csr_rdata[7], "R11 set wins over dma clear", csr_rdata[7], 1);
    while (cnt < 3) @(negedge clk);
    dma_rd = 1; @(negedge clk); dma_rd = 0;
    check(!csr_rdata[7], "R5 dma clear off collision", csr_rdata[7], 0);
    wr(8'h00);
    wr(8'h00);
    clr_flag(8'h00);

    // R10 abort by write in single mode
    saved = get_res(2'd3);
    wr(8'h23);
    @(negedge clk);
    wr(8'h03);
    repeat (LAT + 4) @(negedge clk);
    res_sel = 2'd3; #1;
    check(!csr_rdata[7] && !csr_rdata[5], "R10 abort no flag", csr_rdata, 8'h03);
    check(res_data == saved, "R10 abort no result", res_data, saved);
    last_data[3] = saved;
    // R10 standby abort
    wr(8'h23);
    @(negedge clk); standby = 1; @(negedge clk); standby = 0;
    repeat (LAT + 4) @(negedge clk);
    #1;
    check(!csr_rdata[7] && !csr_rdata[5] && res_data == saved, "R10 standby abort", res_data, saved);
    last_data[3] = saved;

    // R9 trigger enabled, channel 1
    wr(8'h09);
    trig_in = 1; repeat (4) @(negedge clk); trig_in = 0;
    wait_flag("R9 trigger conversion");
    res_sel = 2'd1; #1;
    check(res_data == get_res(2'd1) && !csr_rdata[5], "R9 trigger result", res_data, get_res(2'd1));
    clr_flag(8'h01);
    // R9 trigger disabled
    s0 = nstart;
    trig_in = 1; repeat (4) @(negedge clk); trig_in = 0;
    repeat (10) @(negedge clk);
    check(nstart == s0 && !csr_rdata[5], "R9 trigger disabled", nstart - s0, 0);

    // random single conversions
    for (int i = 0; i < 24; i++) begin
      logic [1:0] ch;
      logic en;
      ch = 2'($urandom % 4);
      en = 1'($urandom % 2);
      wr({1'b0, en, 1'b1, 5'b0} | {6'b0, ch});
      wait_flag("R2 random flag");
      res_sel = ch; #1;
      check(res_data == get_res(ch), "R2 random result", res_data, get_res(ch));
      check(irq == en && !csr_rdata[5], "R6 random irq", irq, en);
      if ($urandom % 2) begin
        wr({1'b0, en, 6'b0});
        check(csr_rdata[7], "R4 random unarmed", csr_rdata[7], 1);
      end
      clr_flag({1'b0, en, 6'b0});
      check(!csr_rdata[7] && !irq, "R4 random clear", csr_rdata[7], 0);
    end

    summary();
    $finish;
  end
endmodule